// File: doc/BRIEF.md
# Lockstep Checkpoint-Retry Recovery Controller

This controller watches a redundant pair of execution units that run one instruction stream in lockstep. Each unit raises a completion strobe at the end of every instruction and presents its full architectural state. On each strobe the controller compares the two state vectors. If they agree, the controller stores the agreed vector as the last known-good checkpoint. If they disagree, it raises a sticky machine-check level and requests one re-execution on the same pair. While requesting the re-execution, it presents the checkpoint so that the units can reload from it.

If the re-execution agrees, the event counts as a soft error and the stream continues. If the re-execution disagrees, the pair is marked bad. The checkpoint then streams one word per cycle into a spare unit, and the spare takes over when the stream ends. A hard failure while the spare is already in service leaves no spare to use, so the controller locks into a failed state. All status outputs are sticky and clear only on reset.

Top module: `lockstep_recovery_ctrl`

## Requirements
- R1: When both strobes are high in the same cycle with equal state vectors, and the controller is accepting strobes, `ckpt_o` equals that vector after the next clock edge.
- R2: A strobe where only one unit's strobe is high, or where the two vectors differ, leaves `ckpt_o` unchanged. It also sets `machine_check_o`, which stays high until reset.
- R3: After a mismatch in normal or spare operation, `retry_o` is high for exactly the one cycle after the strobe edge, and `ckpt_o` holds the checkpoint during it. Strobes sampled during that pulse cycle are ignored.
- R4: A matching strobe after the retry pulse increments `soft_err_cnt_o` by one and updates the checkpoint. The count saturates at 2^CNT_W-1.
- R5: A second mismatch after the retry pulse, with no spare in service, sets the sticky `unit_bad_o` and starts a restore. During the restore, `restore_valid_o` is high for NUM_WORDS consecutive cycles, starting the cycle after that strobe edge. In those cycles `restore_idx_o` counts 0 to NUM_WORDS-1, and `restore_word_o` carries checkpoint bits [idx*WORD_W +: WORD_W].
- R6: `restore_done_o` is high only together with the last restore word. From the next cycle on, `spare_active_o` is high and stays high until reset.
- R7: Strobes arriving during the restore are ignored, and the checkpoint keeps its value.
- R8: A second mismatch after a retry while the spare is in service sets the sticky `failed_o` and produces no restore. Strobes seen afterwards leave `ckpt_o` unchanged.
- R9: While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_a_i | input | 1 | Instruction-complete strobe, unit A |
| done_b_i | input | 1 | Instruction-complete strobe, unit B |
| state_a_i | input | WORD_W*NUM_WORDS | Architectural state, unit A |
| state_b_i | input | WORD_W*NUM_WORDS | Architectural state, unit B |
| retry_o | output | 1 | One-cycle re-execution request |
| ckpt_o | output | WORD_W*NUM_WORDS | Last known-good checkpoint |
| restore_valid_o | output | 1 | Restore word valid |
| restore_idx_o | output | clog2(NUM_WORDS) | Index of the restore word |
| restore_word_o | output | WORD_W | Checkpoint word being restored |
| restore_done_o | output | 1 | High with the last restore word |
| spare_active_o | output | 1 | Spare unit in service (sticky) |
| unit_bad_o | output | 1 | Original pair marked bad (sticky) |
| machine_check_o | output | 1 | Any mismatch seen (sticky) |
| failed_o | output | 1 | Unrecoverable: no spare left (sticky) |
| soft_err_cnt_o | output | CNT_W | Saturating soft error count |

## Verification
The comparison is driven with equal vectors, with vectors that differ in a single low bit, and with a strobe from only one unit. This separates a checkpoint update from a machine check, and shows that a lone strobe is not taken as agreement. Retry outcomes are tried both ways, first on the original pair and then on the spare. This separates the soft-error path from the restore path and from the final failure. Strobes are also injected during the retry pulse and during the restore, which shows that the controller ignores input while it owns the units. Enough soft errors are driven to reach and pass the counter's ceiling.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_RETRY,
    ST_RESTORE,
    ST_SPARE,
    ST_FAILED
  } lsr_state_e;
endpackage

// File: rtl/lsr_compare.sv
module lsr_compare #(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 4,
  localparam int STATE_W  = WORD_W * NUM_WORDS
) (
  input  logic               done_a_i,
  input  logic               done_b_i,
  input  logic [STATE_W-1:0] state_a_i,
  input  logic [STATE_W-1:0] state_b_i,
  output logic               strobe_o,
  output logic               agree_o
);
  logic [NUM_WORDS-1:0] word_eq;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign word_eq[w] = state_a_i[w*WORD_W +: WORD_W] == state_b_i[w*WORD_W +: WORD_W];
  end

  assign strobe_o = done_a_i | done_b_i;
  // a lone strobe never counts as agreement
  assign agree_o  = done_a_i & done_b_i & (&word_eq);
endmodule

// File: rtl/lsr_ckpt.sv
module lsr_ckpt #(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 4,
  localparam int STATE_W  = WORD_W * NUM_WORDS,
  localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [STATE_W-1:0] data_i,
  input  logic [IDX_W-1:0]   sel_i,
  output logic [STATE_W-1:0] ckpt_o,
  output logic [WORD_W-1:0]  word_o
);
  logic [STATE_W-1:0] ckpt_q;
  logic [WORD_W-1:0]  words [NUM_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ckpt_q <= '0;
    else if (load_i) ckpt_q <= data_i;
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_split
    assign words[w] = ckpt_q[w*WORD_W +: WORD_W];
  end

  assign ckpt_o = ckpt_q;
  assign word_o = words[sel_i];
endmodule

// File: rtl/lsr_sat_counter.sv
module lsr_sat_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (inc_i && cnt_q != '1) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/lockstep_recovery_ctrl.sv
module lockstep_recovery_ctrl
  import lsr_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 4,
  parameter int CNT_W     = 4,
  localparam int STATE_W  = WORD_W * NUM_WORDS,
  localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               done_a_i,
  input  logic               done_b_i,
  input  logic [STATE_W-1:0] state_a_i,
  input  logic [STATE_W-1:0] state_b_i,
  output logic               retry_o,
  output logic [STATE_W-1:0] ckpt_o,
  output logic               restore_valid_o,
  output logic [IDX_W-1:0]   restore_idx_o,
  output logic [WORD_W-1:0]  restore_word_o,
  output logic               restore_done_o,
  output logic               spare_active_o,
  output logic               unit_bad_o,
  output logic               machine_check_o,
  output logic               failed_o,
  output logic [CNT_W-1:0]   soft_err_cnt_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_WORDS - 1);

  lsr_state_e       state_q, state_d;
  logic             retry_q, retry_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             spare_q, spare_d;
  logic             bad_q, bad_d;
  logic             mc_q, mc_d;
  logic             strobe, agree, ckpt_load, soft_inc;

  lsr_compare #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_cmp (
    .done_a_i (done_a_i),
    .done_b_i (done_b_i),
    .state_a_i(state_a_i),
    .state_b_i(state_b_i),
    .strobe_o (strobe),
    .agree_o  (agree)
  );

  lsr_ckpt #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_ckpt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(ckpt_load),
    .data_i(state_a_i),
    .sel_i (idx_q),
    .ckpt_o(ckpt_o),
    .word_o(restore_word_o)
  );

  lsr_sat_counter #(.CNT_W(CNT_W)) u_soft (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (soft_inc),
    .count_o(soft_err_cnt_o)
  );

  always_comb begin
    state_d   = state_q;
    retry_d   = 1'b0;
    idx_d     = idx_q;
    spare_d   = spare_q;
    bad_d     = bad_q;
    mc_d      = mc_q;
    soft_inc  = 1'b0;
    ckpt_load = 1'b0;
    unique case (state_q)
      ST_RUN, ST_SPARE: begin
        if (strobe) begin
          if (agree) begin
            ckpt_load = 1'b1;
          end else begin
            mc_d    = 1'b1;
            retry_d = 1'b1;
            state_d = ST_RETRY;
          end
        end
      end
      ST_RETRY: begin
        // strobes during the request pulse are ignored
        if (!retry_q && strobe) begin
          if (agree) begin
            ckpt_load = 1'b1;
            soft_inc  = 1'b1;
            state_d   = spare_q ? ST_SPARE : ST_RUN;
          end else if (spare_q) begin
            state_d = ST_FAILED;
          end else begin
            bad_d   = 1'b1;
            idx_d   = '0;
            state_d = ST_RESTORE;
          end
        end
      end
      ST_RESTORE: begin
        if (idx_q == IDX_LAST) begin
          spare_d = 1'b1;
          state_d = ST_SPARE;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      retry_q <= 1'b0;
      idx_q   <= '0;
      spare_q <= 1'b0;
      bad_q   <= 1'b0;
      mc_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      retry_q <= retry_d;
      idx_q   <= idx_d;
      spare_q <= spare_d;
      bad_q   <= bad_d;
      mc_q    <= mc_d;
    end
  end

  assign retry_o         = retry_q;
  assign restore_valid_o = state_q == ST_RESTORE;
  assign restore_idx_o   = idx_q;
  assign restore_done_o  = restore_valid_o && idx_q == IDX_LAST;
  assign spare_active_o  = spare_q;
  assign unit_bad_o      = bad_q;
  assign machine_check_o = mc_q;
  assign failed_o        = state_q == ST_FAILED;
endmodule

// File: rtl/lsr_checker.sv
module lsr_checker #(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 4,
  parameter int CNT_W     = 4,
  localparam int STATE_W  = WORD_W * NUM_WORDS,
  localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               done_a_i,
  input logic               done_b_i,
  input logic [STATE_W-1:0] state_a_i,
  input logic [STATE_W-1:0] state_b_i,
  input logic               retry_o,
  input logic [STATE_W-1:0] ckpt_o,
  input logic               restore_valid_o,
  input logic [IDX_W-1:0]   restore_idx_o,
  input logic               restore_done_o,
  input logic               spare_active_o,
  input logic               unit_bad_o,
  input logic               machine_check_o,
  input logic               failed_o,
  input logic [CNT_W-1:0]   soft_err_cnt_o
);
  logic disagree;
  assign disagree = (done_a_i || done_b_i) && !(done_a_i && done_b_i && state_a_i == state_b_i);

  assert_ckpt_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disagree |=> $stable(ckpt_o));
  assert_mc_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    machine_check_o |=> machine_check_o);
  assert_retry_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |=> !retry_o);
  assert_retry_after_mc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> machine_check_o);
  assert_cnt_monotonic_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> soft_err_cnt_o >= $past(soft_err_cnt_o));
  assert_bad_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_bad_o |=> unit_bad_o);
  assert_restore_has_bad_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_valid_o |-> unit_bad_o);
  assert_done_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_done_o |-> restore_valid_o && restore_idx_o == IDX_W'(NUM_WORDS - 1));
  assert_done_then_spare_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_done_o |=> spare_active_o && !restore_valid_o);
  assert_failed_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    failed_o |=> failed_o && !restore_valid_o && $stable(ckpt_o));
endmodule

bind lockstep_recovery_ctrl lsr_checker #(
  .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .CNT_W(CNT_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .done_a_i       (done_a_i),
  .done_b_i       (done_b_i),
  .state_a_i      (state_a_i),
  .state_b_i      (state_b_i),
  .retry_o        (retry_o),
  .ckpt_o         (ckpt_o),
  .restore_valid_o(restore_valid_o),
  .restore_idx_o  (restore_idx_o),
  .restore_done_o (restore_done_o),
  .spare_active_o (spare_active_o),
  .unit_bad_o     (unit_bad_o),
  .machine_check_o(machine_check_o),
  .failed_o       (failed_o),
  .soft_err_cnt_o (soft_err_cnt_o)
);

// File: tb/lockstep_recovery_ctrl_bench.sv
module lockstep_recovery_ctrl_bench;
  localparam int WORD_W    = 16;
  localparam int NUM_WORDS = 4;
  localparam int CNT_W     = 4;
  localparam int STATE_W   = WORD_W * NUM_WORDS;
  localparam int IDX_W     = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst_n;
  logic               done_a, done_b;
  logic [STATE_W-1:0] st_a, st_b;
  logic               retry, rvalid, rdone, spare, bad, mc, failed;
  logic [STATE_W-1:0] ckpt;
  logic [IDX_W-1:0]   ridx;
  logic [WORD_W-1:0]  rword;
  logic [CNT_W-1:0]   scnt;

  lockstep_recovery_ctrl #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .CNT_W(CNT_W)) u_lockstep_recovery_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .done_a_i(done_a), .done_b_i(done_b),
    .state_a_i(st_a), .state_b_i(st_b), .retry_o(retry), .ckpt_o(ckpt),
    .restore_valid_o(rvalid), .restore_idx_o(ridx), .restore_word_o(rword),
    .restore_done_o(rdone), .spare_active_o(spare), .unit_bad_o(bad),
    .machine_check_o(mc), .failed_o(failed), .soft_err_cnt_o(scnt)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  typedef struct {
    bit                 is_restore;
    logic [STATE_W-1:0] val;
    int                 idx;
    bit                 last;
  } exp_t;
  exp_t exp_q[$];

  logic [STATE_W-1:0] cur;

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_retry(logic [STATE_W-1:0] c);
    exp_t e;
    e.is_restore = 1'b0; e.val = c; e.idx = 0; e.last = 1'b0;
    exp_q.push_back(e);
  endtask

  task automatic expect_restore(logic [STATE_W-1:0] c);
    for (int w = 0; w < NUM_WORDS; w++) begin
      exp_t e;
      e.is_restore = 1'b1;
      e.val  = STATE_W'(c[w*WORD_W +: WORD_W]);
      e.idx  = w;
      e.last = (w == NUM_WORDS - 1);
      exp_q.push_back(e);
    end
  endtask

  // drive one strobe cycle; returns at the negedge after the capturing edge
  task automatic strobe(bit now, bit da, bit db, logic [STATE_W-1:0] sa, logic [STATE_W-1:0] sb);
    if (!now) @(negedge clk);
    done_a = da; done_b = db; st_a = sa; st_b = sb;
    @(negedge clk);
    done_a = 1'b0; done_b = 1'b0;
  endtask

  // monitor: pops scoreboard items as retry pulses and restore words appear
  always @(negedge clk) begin
    if (rst_n && (retry || rvalid)) begin
      if (exp_q.size() == 0 || exp_q[0].is_restore != rvalid) begin
        check(rvalid ? "R5" : "R3", "unexpected event", {62'd0, retry, rvalid}, 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.is_restore) begin
          check("R5", "restore word", 64'(rword), e.val);
          check("R5", "restore idx", 64'(ridx), 64'(e.idx));
          check("R6", "restore done", 64'(rdone), 64'(e.last));
        end else begin
          check("R3", "ckpt with retry", ckpt, e.val);
        end
      end
    end
  end

  task automatic soft_event(logic [STATE_W-1:0] good);
    expect_retry(cur);
    strobe(1'b0, 1'b1, 1'b1, good, good ^ 64'h1);
    strobe(1'b0, 1'b1, 1'b1, good, good);
    cur = good;
  endtask

  task automatic check_idle_outputs(string req);
    check(req, "retry", 64'(retry), 0);
    check(req, "ckpt", ckpt, 0);
    check(req, "restore_valid", 64'(rvalid), 0);
    check(req, "spare", 64'(spare), 0);
    check(req, "bad", 64'(bad), 0);
    check(req, "mc", 64'(mc), 0);
    check(req, "failed", 64'(failed), 0);
    check(req, "soft_cnt", 64'(scnt), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; done_a = 1'b0; done_b = 1'b0; st_a = '0; st_b = '0; cur = '0;
    repeat (3) @(negedge clk);
    check_idle_outputs("R9");
    rst_n = 1'b1;

    // R1 agreed state becomes checkpoint
    strobe(1'b0, 1'b1, 1'b1, 64'h1111_2222_3333_4444, 64'h1111_2222_3333_4444);
    check("R1", "ckpt after match", ckpt, 64'h1111_2222_3333_4444);
    strobe(1'b0, 1'b1, 1'b1, 64'hA5A5_0F0F_DEAD_BEEF, 64'hA5A5_0F0F_DEAD_BEEF);
    check("R1", "ckpt after match 2", ckpt, 64'hA5A5_0F0F_DEAD_BEEF);
    cur = 64'hA5A5_0F0F_DEAD_BEEF;
    check("R2", "mc before fault", 64'(mc), 0);

    // R2 lone strobe is a mismatch; R3 strobe in pulse cycle ignored
    expect_retry(cur);
    strobe(1'b0, 1'b1, 1'b0, 64'h7, 64'h7);
    check("R2", "mc after lone strobe", 64'(mc), 1);
    check("R2", "ckpt held", ckpt, cur);
    check("R3", "retry high", 64'(retry), 1);
    strobe(1'b1, 1'b1, 1'b1, 64'h9999, 64'h9999);
    check("R3", "retry dropped", 64'(retry), 0);
    check("R3", "ckpt after pulse-cycle strobe", ckpt, cur);
    check("R3", "soft cnt after pulse-cycle strobe", 64'(scnt), 0);
    strobe(1'b0, 1'b1, 1'b1, 64'h3333_0000_3333_0000, 64'h3333_0000_3333_0000);
    cur = 64'h3333_0000_3333_0000;
    check("R4", "soft cnt 1", 64'(scnt), 1);
    check("R4", "ckpt after retry match", ckpt, cur);
    check("R5", "bad still low", 64'(bad), 0);

    // R5 hard failure -> restore into spare, R7 strobes ignored meanwhile
    expect_retry(cur);
    strobe(1'b0, 1'b1, 1'b1, 64'h44, 64'h45);
    expect_restore(cur);
    strobe(1'b0, 1'b0, 1'b1, 64'h44, 64'h44);
    check("R5", "restore started", 64'(rvalid), 1);
    check("R5", "bad set", 64'(bad), 1);
    strobe(1'b1, 1'b1, 1'b1, 64'hBEEF, 64'hBEEF);
    repeat (NUM_WORDS) @(negedge clk);
    check("R7", "ckpt kept over restore", ckpt, cur);
    check("R6", "spare active", 64'(spare), 1);
    check("R6", "restore finished", 64'(rvalid), 0);
    check("R5", "restore words consumed", 64'(exp_q.size()), 0);

    // on the spare
    strobe(1'b0, 1'b1, 1'b1, 64'h5555_6666_7777_8888, 64'h5555_6666_7777_8888);
    cur = 64'h5555_6666_7777_8888;
    check("R1", "ckpt on spare", ckpt, cur);
    for (int k = 0; k < 14; k++) soft_event({4{16'(k + 16'h100)}});
    check("R4", "soft cnt at ceiling", 64'(scnt), 15);
    check("R6", "spare kept", 64'(spare), 1);
    soft_event(64'hCAFE_CAFE_CAFE_CAFE);
    check("R4", "soft cnt saturated", 64'(scnt), 15);
    check("R4", "ckpt after saturating retry", ckpt, cur);

    // R8 hard failure with spare in use
    expect_retry(cur);
    strobe(1'b0, 1'b1, 1'b1, 64'h1, 64'h2);
    strobe(1'b0, 1'b1, 1'b1, 64'h1, 64'h3);
    check("R8", "failed set", 64'(failed), 1);
    strobe(1'b0, 1'b1, 1'b1, 64'hF00D, 64'hF00D);
    repeat (NUM_WORDS + 1) @(negedge clk);
    check("R8", "no restore", 64'(rvalid), 0);
    check("R8", "ckpt frozen", ckpt, cur);
    check("R8", "still failed", 64'(failed), 1);
    check("R3", "scoreboard empty", 64'(exp_q.size()), 0);

    // R9 reset clears sticky state
    rst_n = 1'b0;
    @(negedge clk);
    check_idle_outputs("R9");
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule